// File: doc/BRIEF.md
# Multi-CPU Leveled Interrupt Controller

This block gathers 32 level-sensitive device interrupt lines and one private timer line per CPU. It turns them into a vector of priority-level request lines for each CPU. Every device line has a fixed interrupt level, computed as (bit index mod 15) + 1. Device lines are masked by one shared disable register and are steered to a single target CPU that software selects. Each CPU also has its own local pending register. The upper part of that register holds software interrupts, which are merged into that CPU's level vector after a shift.

Software reaches the block over a simple word-addressed bus. One bank select opens the master window, which holds the pending, disable and target registers. One further select per CPU opens that CPU's local window. Reads are combinational. Writes take effect at the clock edge. The per-CPU level outputs are registered.

Top module: `irq_router`

## Requirements
- R1: A change on device line j (seen against its value one clock earlier) sets or clears bit j of the master pending register. On the same edge it sets or clears bit (j mod 15)+1 of the current target CPU's local pending register.
- R2: Reading master word 0 returns the master pending register with bit 31 forced to 0.
- R3: Reading master word 1 returns the disable register ANDed with the implemented mask, where the mask is the complement of 0x0FA2007F. Writes to the disable register never change bits outside the mask.
- R4: Writing master word 2 clears every disable bit that is set in the written value and lies within the mask.
- R5: Writing master word 3 sets every disable bit that is set in the written value and lies within the mask. It also clears the same bits of the master pending register.
- R6: Writing master word 4 loads the target CPU from the low log2(NCPU) bits of the written value (bits 1:0 for 4 CPUs).
- R7: Disable bit 31 is a global gate. While it is set, no device source reaches any CPU's level vector. Reset clears all pending registers, loads the disable register with 0x0FA2007F and selects CPU 0 as target.
- R8: In CPU window c, a write to word 2 ORs the written value, limited to bits 31:17, into local pending. A write to word 1 clears the written bits within 31:17, and written bit 14 additionally clears bit 31. Reading word 0 returns the local pending register.
- R9: Level vector bit L of CPU c is set in two cases. The first is that c is the target, the global gate is off, and some pending, enabled source maps to L. The second is that local pending bit L+16 is set, for L from 1 to 15. The output shows this one clock after the state it is computed from.
- R10: A change on CPU c's timer line sets or clears master pending bit 19. It also sets or clears local pending bit 5 of CPU c.
- R11: Reads of unimplemented offsets return 0: master words other than 0 and 1, and CPU words other than 0. Writes to unimplemented offsets change nothing: master words other than 2 to 4, and CPU words other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 32 | Device interrupt levels |
| tmr | input | NCPU | Per-CPU private timer levels |
| m_sel | input | 1 | Master window select |
| c_sel | input | NCPU | Per-CPU window selects |
| wr | input | 1 | Write strobe for the selected window |
| addr | input | 3 | Word offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected window |
| lvl_out | output | NCPU*NLVL | Level request vectors, CPU c at bits c*NLVL +: NLVL |

## Verification
The assertions take for granted that at most one bank select is high in any cycle. They also assume that software interrupt bits change only through CPU window writes. This holds because device and timer events only touch local bits 15 and below. The stimulus drives exactly one select per access and drops it before selecting another bank. Device and timer lines change only between accesses, so each register effect can be attributed to a single cause.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NCPU    = 4,
  parameter int NLVL    = 16,
  parameter int TMR_BIT = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          src,
  input  logic [NCPU-1:0]      tmr,
  input  logic                 m_sel,
  input  logic [NCPU-1:0]      c_sel,
  input  logic                 wr,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NCPU*NLVL-1:0] lvl_out
);
  localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam logic [31:0] UNIMP = 32'h0FA2007F;
  localparam logic [31:0] MASK  = ~UNIMP;
  localparam logic [31:0] SOFT  = 32'hFFFE0000;

  function automatic logic [4:0] lvl_of(input int j);
    return 5'((j % 15) + 1);
  endfunction

  logic [31:0]     mpend, dis, src_q;
  logic [NCPU-1:0] tmr_q;
  logic [TW-1:0]   tgt;
  logic [31:0]     lpend [NCPU];
  logic [NLVL-1:0] lvl_q [NCPU];

  logic [31:0]     mpend_n, dis_n;
  logic [31:0]     lpend_n [NCPU];
  logic [TW-1:0]   tgt_n;
  logic [NLVL-1:0] dev_lv;

  always_comb begin
    mpend_n = mpend;
    dis_n   = dis;
    tgt_n   = tgt;
    lpend_n = lpend;
    for (int j = 0; j < 32; j++)
      if (src[j] != src_q[j]) begin
        mpend_n[j] = src[j];
        lpend_n[tgt][lvl_of(j)] = src[j];
      end
    for (int c = 0; c < NCPU; c++)
      if (tmr[c] != tmr_q[c]) begin
        mpend_n[TMR_BIT] = tmr[c];
        lpend_n[c][lvl_of(TMR_BIT)] = tmr[c];
      end
    if (wr && m_sel)
      case (addr)
        3'd2: dis_n = dis & ~(wdata & MASK);
        3'd3: begin
          dis_n   = dis | (wdata & MASK);
          mpend_n = mpend_n & ~(wdata & MASK);
        end
        3'd4: tgt_n = wdata[TW-1:0];
        default: ;
      endcase
    for (int c = 0; c < NCPU; c++)
      if (wr && c_sel[c])
        case (addr)
          3'd1: lpend_n[c] = lpend_n[c] & ~((wdata | {wdata[14], 31'b0}) & SOFT);
          3'd2: lpend_n[c] = lpend_n[c] | (wdata & SOFT);
          default: ;
        endcase
  end

  always_comb begin
    dev_lv = '0;
    for (int j = 0; j < 32; j++)
      if (mpend[j] && !dis[j]) dev_lv[lvl_of(j)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mpend <= '0;
      dis   <= UNIMP;
      tgt   <= '0;
      src_q <= '0;
      tmr_q <= '0;
      for (int c = 0; c < NCPU; c++) begin
        lpend[c] <= '0;
        lvl_q[c] <= '0;
      end
    end else begin
      mpend <= mpend_n;
      dis   <= dis_n;
      tgt   <= tgt_n;
      src_q <= src;
      tmr_q <= tmr;
      for (int c = 0; c < NCPU; c++) begin
        lpend[c] <= lpend_n[c];
        lvl_q[c] <= (((tgt == TW'(c)) && !dis[31]) ? dev_lv : '0)
                  | NLVL'({lpend[c][31:17], 1'b0});
      end
    end

  always_comb begin
    rdata = '0;
    if (m_sel)
      case (addr)
        3'd0: rdata = mpend & 32'h7FFFFFFF;
        3'd1: rdata = dis & MASK;
        default: ;
      endcase
    for (int c = 0; c < NCPU; c++)
      if (c_sel[c] && addr == 3'd0) rdata = lpend[c];
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_out
    assign lvl_out[c*NLVL +: NLVL] = lvl_q[c];
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCPU = 4,
  parameter int NLVL = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 m_sel,
  input logic [NCPU-1:0]      c_sel,
  input logic                 wr,
  input logic [2:0]           addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NCPU*NLVL-1:0] lvl_out,
  input logic [31:0]          mpend,
  input logic [31:0]          dis,
  input logic [31:0]          lpend [NCPU]
);
  localparam logic [31:0] MASK = ~32'h0FA2007F;

  AST_PEND_TOP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && addr == 3'd0) |-> !rdata[31]); // R2
  AST_DIS_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && addr == 3'd1) |-> ((rdata & ~MASK) == 32'h0)); // R3
  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && wr && addr == 3'd2) |=> ((dis & $past(wdata) & MASK) == 32'h0)); // R4
  AST_DISABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && wr && addr == 3'd3) |=>
      (((dis & $past(wdata) & MASK) == ($past(wdata) & MASK)) &&
       ((mpend & $past(wdata) & MASK) == 32'h0))); // R5
  AST_UNIMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sel && wr && addr > 3'd4) |=> (dis == $past(dis))); // R11

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dis[31]) && ($past(lpend[c][31:17]) == 15'h0)) |->
        (lvl_out[c*NLVL +: NLVL] == '0)); // R7
    AST_SOFT_CLR15: assert property (@(posedge clk) disable iff (!rst_n)
      (c_sel[c] && wr && addr == 3'd1 && wdata[14]) |=> !lpend[c][31]); // R8
  end
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU), .NLVL(NLVL)) u_chk (.*);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int NC = 4;
  localparam int NL = 16;

  logic clk = 0, rst_n = 0;
  logic [31:0] src = 0, wdata = 0;
  logic [NC-1:0] tmr = 0, c_sel = 0;
  logic m_sel = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [31:0] rdata;
  logic [NC*NL-1:0] lvl_out;

  irq_router u0 (.clk, .rst_n, .src, .tmr, .m_sel, .c_sel, .wr, .addr,
                 .wdata, .rdata, .lvl_out);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] mp, md, sq;
  logic [31:0] lp [NC];
  logic [15:0] ml [NC];
  logic [15:0] nl [NC];
  logic [NC-1:0] tq;
  int tg;

  function automatic int lv(int j); return (j % 15) + 1; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp = 0; md = 32'h0FA2007F; sq = 0; tq = 0; tg = 0;
      for (int c = 0; c < NC; c++) begin lp[c] = 0; ml[c] = 0; end
    end else begin
      for (int c = 0; c < NC; c++) begin
        nl[c] = (lp[c] & 32'hFFFE0000) >> 16;
        if (c == tg && !md[31])
          for (int j = 0; j < 32; j++)
            if (mp[j] && !md[j]) nl[c][lv(j)] = 1'b1;
      end
      for (int j = 0; j < 32; j++)
        if (src[j] != sq[j]) begin mp[j] = src[j]; lp[tg][lv(j)] = src[j]; end
      for (int c = 0; c < NC; c++)
        if (tmr[c] != tq[c]) begin mp[19] = tmr[c]; lp[c][5] = tmr[c]; end
      if (wr && m_sel) begin
        if (addr == 2) md = md & ~(wdata & ~32'h0FA2007F);
        if (addr == 3) begin
          md = md | (wdata & ~32'h0FA2007F);
          mp = mp & ~(wdata & ~32'h0FA2007F);
        end
        if (addr == 4) tg = int'(wdata % NC);
      end
      for (int c = 0; c < NC; c++)
        if (wr && c_sel[c]) begin
          if (addr == 1) lp[c] = lp[c] & ~((wdata | (wdata[14] ? 32'h80000000 : 0)) & 32'hFFFE0000);
          if (addr == 2) lp[c] = lp[c] | (wdata & 32'hFFFE0000);
        end
      sq = src; tq = tmr;
      for (int c = 0; c < NC; c++) ml[c] = nl[c];
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = 0;
    if (m_sel && addr == 0) r = mp & 32'h7FFFFFFF;
    if (m_sel && addr == 1) r = md & ~32'h0FA2007F;
    for (int c = 0; c < NC; c++) if (c_sel[c] && addr == 0) r = lp[c];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    for (int c = 0; c < NC; c++)
      chk("R9 model lvl", 32'(lvl_out[c*NL +: NL]), 32'(ml[c]));
    chk("R2 model rdata", rdata, exp_rd());
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      m_sel = 0; c_sel = 0; wr = 0; addr = 0; wdata = 0;
    end
  endtask

  task automatic wreg(bit m, int cpu, int a, logic [31:0] d);
    @(negedge clk); #1;
    m_sel = m; c_sel = m ? '0 : NC'(1 << cpu); wr = 1; addr = 3'(a); wdata = d;
    idle(1);
  endtask

  task automatic rreg(bit m, int cpu, int a, output logic [31:0] d);
    @(negedge clk); #1;
    m_sel = m; c_sel = m ? '0 : NC'(1 << cpu); wr = 0; addr = 3'(a);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] lvl(int c);
    return 32'(lvl_out[c*NL +: NL]);
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(1);
    rreg(1, 0, 1, d); chk("R7 reset disable readback", d, 32'h0);
    chk("R9 reset lvl", 32'(lvl_out), 32'h0);
    rreg(1, 0, 0, d); chk("R7 reset pending", d, 32'h0);

    src[8] = 1; idle(3);
    chk("R1 R9 cpu0 lvl from src8", lvl(0), 32'h0200);
    rreg(1, 0, 0, d); chk("R1 R2 master pending", d, 32'h100);
    rreg(0, 0, 0, d); chk("R1 cpu0 local bit9", d, 32'h200);

    wreg(1, 0, 4, 32'h2); idle(2);
    chk("R6 cpu0 lvl after retarget", lvl(0), 32'h0);
    chk("R6 cpu2 lvl after retarget", lvl(2), 32'h0200);

    wreg(1, 0, 3, 32'h100); idle(2);
    rreg(1, 0, 1, d); chk("R5 disable set", d, 32'h100);
    rreg(1, 0, 0, d); chk("R5 pending cleared", d, 32'h0);
    chk("R5 cpu2 lvl", lvl(2), 32'h0);

    wreg(1, 0, 2, 32'h100); idle(2);
    rreg(1, 0, 1, d); chk("R4 disable cleared", d, 32'h0);
    wreg(1, 0, 3, 32'h8);
    rreg(1, 0, 1, d); chk("R3 unimplemented bit stays hidden", d, 32'h0);

    wreg(1, 0, 3, 32'h80000000);
    src[10] = 1; src[31] = 1; idle(3);
    rreg(1, 0, 1, d); chk("R7 global disable readback", d, 32'h80000000);
    rreg(1, 0, 0, d); chk("R2 bit31 hidden", d, 32'h400);
    chk("R7 gated cpu2 lvl", lvl(2), 32'h0);

    wreg(0, 1, 2, 32'hFFFFFFFF); idle(2);
    rreg(0, 1, 0, d); chk("R8 soft set", d, 32'hFFFE0000);
    chk("R8 R9 cpu1 soft lvl", lvl(1), 32'hFFFE);
    wreg(0, 1, 1, 32'h00004000); idle(2);
    rreg(0, 1, 0, d); chk("R8 bit14 clears 31", d, 32'h7FFE0000);
    chk("R8 cpu1 lvl", lvl(1), 32'h7FFE);
    wreg(0, 1, 1, 32'h00020000); idle(2);
    rreg(0, 1, 0, d); chk("R8 clear bit17", d, 32'h7FFC0000);

    tmr[3] = 1; idle(3);
    rreg(1, 0, 0, d); chk("R10 timer master bit", d, 32'h00080400);
    rreg(0, 3, 0, d); chk("R10 timer local bit", d, 32'h20);
    tmr[3] = 0; idle(3);
    rreg(1, 0, 0, d); chk("R10 timer release", d, 32'h400);
    rreg(0, 3, 0, d); chk("R10 timer local release", d, 32'h0);

    wreg(1, 0, 2, 32'h80000000); idle(2);
    chk("R9 cpu2 device lvl", lvl(2), 32'h0804);
    chk("R9 cpu1 keeps soft", lvl(1), 32'h7FFC);
    wreg(1, 0, 4, 32'h7); idle(2);
    chk("R6 low bits target cpu3", lvl(3), 32'h0804);
    chk("R6 cpu2 dropped", lvl(2), 32'h0);

    rreg(1, 0, 5, d); chk("R11 master read word5", d, 32'h0);
    wreg(1, 0, 7, 32'hFFFFFFFF);
    rreg(1, 0, 1, d); chk("R11 write word7 no effect", d, 32'h0);
    rreg(0, 0, 3, d); chk("R11 cpu read word3", d, 32'h0);
    wreg(0, 0, 0, 32'hFFFFFFFF);
    rreg(0, 0, 0, d); chk("R11 cpu write word0 no effect", d, 32'h200);
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule